// File: doc/BRIEF.md
# Block Refill Unit with Early Word Release

This unit sits between a cache and a memory port that returns one word per beat. When the cache reports a miss, the unit sends a single line request to memory. The request names the word that the processor is waiting for. As the beats arrive, the unit writes each word into the cache line. In the cycle that the wanted word appears on the memory port, the unit also hands that word straight to the processor and releases it. The remaining words keep filling in the background.

A per-miss order input selects between two fill orders. In wrapped order, memory starts at the wanted word and continues upward, wrapping past the top of the line back to word 0. The processor is therefore released on the first beat. In linear order, memory starts at word 0 and climbs. The processor is released on whichever beat carries the wanted word.

While a fill is in progress the unit is busy and refuses further misses. The processor may read any word of the line being filled, but only once that word has been written. The cache marks the line valid from the end-of-fill pulse. Tags and replacement are handled elsewhere.

Top module: `crit_fill_unit`

## Requirements
- R1: While reset is held and directly after it, busy, mem_req_valid, fill_we, line_done, cpu_resume and rd_ready are all 0.
- R2: A miss_valid while not busy raises mem_req_valid in the same cycle, with mem_req_line equal to miss_line. mem_req_word equals miss_word when miss_wrap is 1, and 0 when miss_wrap is 0. busy is 1 from the next cycle.
- R3: With miss_wrap=1, the k-th memory beat (k counted from 0) writes word index (miss_word + k) mod WORDS, with fill_data equal to mem_rdata.
- R4: With miss_wrap=0, the k-th memory beat writes word index k.
- R5: cpu_resume is 1 for exactly one cycle per miss: the cycle of the beat that carries the requested word. In that cycle cpu_resume_data equals mem_rdata. In wrapped order this is beat 0; in linear order it is beat miss_word.
- R6: line_done is 1 only in the cycle of beat WORDS-1, and busy is 0 from the following cycle.
- R7: miss_valid while busy is ignored: mem_req_valid stays 0 and the fill in progress continues unchanged.
- R8: mem_rvalid while not busy is ignored: fill_we, cpu_resume and line_done stay 0.
- R9: When rd_valid is 1, rd_ready is 1 only if word rd_word was written by a beat in an earlier cycle, and rd_data then holds that word. A read of a word in the same cycle that its beat arrives gives rd_ready=0.
- R10: Accepting a new miss discards the written state of the previous line: in the cycle after acceptance, no word reads as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Cache reports a miss this cycle |
| miss_line | input | LINE_W | Line address of the miss |
| miss_word | input | IDX_W | Word within the line that the processor wants |
| miss_wrap | input | 1 | 1: wrapped order from the wanted word; 0: linear order from word 0 |
| busy | output | 1 | Fill in progress; new misses are refused |
| mem_req_valid | output | 1 | Line request to memory (one cycle) |
| mem_req_line | output | LINE_W | Requested line address |
| mem_req_word | output | IDX_W | First word memory must return |
| mem_rvalid | input | 1 | Memory beat strobe |
| mem_rdata | input | DATA_W | Memory beat data |
| fill_we | output | 1 | Write one word into the cache line |
| fill_word | output | IDX_W | Word index being written |
| fill_data | output | DATA_W | Word being written |
| line_done | output | 1 | Last word written; cache may set the line valid |
| cpu_resume | output | 1 | Requested word forwarded; processor released |
| cpu_resume_data | output | DATA_W | The forwarded word |
| rd_valid | input | 1 | Processor reads a word of the current line |
| rd_word | input | IDX_W | Word index to read |
| rd_ready | output | 1 | The read word is present |
| rd_data | output | DATA_W | Data of the read word |

## Verification
Two events can fall into the same cycle. A processor read of a word can coincide with the memory beat that delivers that word. A new miss can arrive while a fill is still in progress; this includes the cycle of the final beat, when line_done is high but busy has not yet dropped.

The bench provokes the first case by driving rd_valid on every beat with that beat's own index. It expects rd_ready=0 in that cycle, and a ready read of the same word in a later gap cycle. It provokes the second case by holding miss_valid high during gaps between beats. It judges the result by mem_req_valid staying 0, and by the beat order and release cycle of the running fill being unaffected.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  // Order in which memory returns the words of a line.
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_WRAP   = 1'b1
  } fill_order_e;
endpackage

// File: rtl/cwf_seq.sv
// Beat sequencer: holds the word index of the next beat and the beat count.
module cwf_seq #(
  parameter int WORDS = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_idx_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic [IDX_W-1:0] idx_q, idx_d, idx_inc;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             seq_en;

  generate
    if ((WORDS & (WORDS - 1)) == 0) begin : g_pow2
      assign idx_inc = idx_q + 1'b1;
    end else begin : g_cmp
      assign idx_inc = (idx_q == IDX_W'(WORDS - 1)) ? '0 : idx_q + 1'b1;
    end
  endgenerate

  assign seq_en = load_i | step_i;

  always_comb begin
    idx_d = idx_q;
    cnt_d = cnt_q;
    if (load_i) begin
      idx_d = load_idx_i;
      cnt_d = '0;
    end else if (step_i) begin
      idx_d = idx_inc;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (seq_en) begin
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  assign idx_o  = idx_q;
  assign last_o = (cnt_q == IDX_W'(WORDS - 1));

  // R3: the beat index never leaves the line
  a_r3_idx_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < WORDS);

  // R3: consecutive beats move to neighbouring words
  a_r3_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !load_i |=> idx_q != $past(idx_q));
endmodule

// File: rtl/cwf_linebuf.sv
// Local copy of the line being filled, with a per-word written mask.
module cwf_linebuf #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic              rfilled_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word_q [WORDS];
  logic [WORDS-1:0]  filled_q, filled_d;
  logic              mask_en;

  generate
    for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic word_en;
      assign word_en = we_i && (widx_i == IDX_W'(i));
      always_ff @(posedge clk) begin
        if (word_en) word_q[i] <= wdata_i;
      end
    end
  endgenerate

  assign mask_en = clr_i | we_i;

  always_comb begin
    filled_d = filled_q;
    if (clr_i) filled_d = '0;
    if (we_i)  filled_d[widx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       filled_q <= '0;
    else if (mask_en) filled_q <= filled_d;
  end

  assign rfilled_o = filled_q[ridx_i];
  assign rdata_o   = word_q[ridx_i];

  // R9: a written word is readable from the next cycle on
  a_r9_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
    we_i && !clr_i |=> filled_q[$past(widx_i)]);

  // R10: a new miss leaves nothing readable
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !we_i |=> filled_q == '0);
endmodule

// File: rtl/cwf_ctrl.sv
// Fill control: acceptance, busy state, release and end-of-line detection.
module cwf_ctrl #(
  parameter int WORDS = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid_i,
  input  logic [IDX_W-1:0] miss_word_i,
  input  logic             miss_wrap_i,
  input  logic             mem_rvalid_i,
  input  logic [IDX_W-1:0] cur_idx_i,
  input  logic             last_i,
  output logic             busy_o,
  output logic             accept_o,
  output logic [IDX_W-1:0] start_idx_o,
  output logic             beat_o,
  output logic             done_o,
  output logic             resume_o
);
  import cwf_pkg::*;

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] crit_q;
  fill_order_e      order;

  assign order       = fill_order_e'(miss_wrap_i);
  assign accept_o    = miss_valid_i && !busy_q;
  assign start_idx_o = (order == ORDER_WRAP) ? miss_word_i : '0;
  assign beat_o      = busy_q && mem_rvalid_i;
  assign done_o      = beat_o && last_i;
  assign resume_o    = beat_o && (cur_idx_i == crit_q);

  always_comb begin
    busy_d = busy_q;
    if (accept_o)    busy_d = 1'b1;
    else if (done_o) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  busy_q <= 1'b0;
    else if (accept_o || done_o) busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crit_q <= '0;
    else if (accept_o) crit_q <= miss_word_i;
  end

  assign busy_o = busy_q;

  // R2: an accepted miss makes the unit busy
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> busy_o);

  // R6: the end-of-line beat frees the unit
  a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R5: release is never repeated on the next beat
  a_r5_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> !resume_o);

  // R8: nothing is written while idle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !beat_o && !resume_o);
endmodule

// File: rtl/crit_fill_unit.sv
module crit_fill_unit #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int LINE_W = 26,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [LINE_W-1:0] miss_line,
  input  logic [IDX_W-1:0]  miss_word,
  input  logic              miss_wrap,
  output logic              busy,
  output logic              mem_req_valid,
  output logic [LINE_W-1:0] mem_req_line,
  output logic [IDX_W-1:0]  mem_req_word,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fill_we,
  output logic [IDX_W-1:0]  fill_word,
  output logic [DATA_W-1:0] fill_data,
  output logic              line_done,
  output logic              cpu_resume,
  output logic [DATA_W-1:0] cpu_resume_data,
  input  logic              rd_valid,
  input  logic [IDX_W-1:0]  rd_word,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_data
);
  logic             accept, beat, last, done, resume, rfilled;
  logic [IDX_W-1:0] start_idx, cur_idx;

  cwf_ctrl #(.WORDS(WORDS)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid_i (miss_valid),
    .miss_word_i  (miss_word),
    .miss_wrap_i  (miss_wrap),
    .mem_rvalid_i (mem_rvalid),
    .cur_idx_i    (cur_idx),
    .last_i       (last),
    .busy_o       (busy),
    .accept_o     (accept),
    .start_idx_o  (start_idx),
    .beat_o       (beat),
    .done_o       (done),
    .resume_o     (resume)
  );

  cwf_seq #(.WORDS(WORDS)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .load_idx_i (start_idx),
    .step_i     (beat),
    .idx_o      (cur_idx),
    .last_o     (last)
  );

  cwf_linebuf #(.WORDS(WORDS), .DATA_W(DATA_W)) buf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (accept),
    .we_i      (beat),
    .widx_i    (cur_idx),
    .wdata_i   (mem_rdata),
    .ridx_i    (rd_word),
    .rfilled_o (rfilled),
    .rdata_o   (rd_data)
  );

  assign mem_req_valid   = accept;
  assign mem_req_line    = miss_line;
  assign mem_req_word    = start_idx;
  assign fill_we         = beat;
  assign fill_word       = cur_idx;
  assign fill_data       = mem_rdata;
  assign line_done       = done;
  assign cpu_resume      = resume;
  assign cpu_resume_data = mem_rdata;
  assign rd_ready        = rd_valid && rfilled;

  // R6: line completion only comes with a written word
  a_r6_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> fill_we);

  // R7: no second request while a fill runs
  a_r7_no_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_req_valid);
endmodule

// File: tb/crit_fill_unit_tb_top.sv
module crit_fill_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS  = 8;
  localparam int DATA_W = 32;
  localparam int LINE_W = 26;
  localparam int IDX_W  = $clog2(WORDS);

  logic              clk, rst_n;
  logic              miss_valid, miss_wrap, mem_rvalid, rd_valid;
  logic [LINE_W-1:0] miss_line, mem_req_line;
  logic [IDX_W-1:0]  miss_word, mem_req_word, fill_word, rd_word;
  logic [DATA_W-1:0] mem_rdata, fill_data, cpu_resume_data, rd_data;
  logic              busy, mem_req_valid, fill_we, line_done, cpu_resume, rd_ready;

  int n_checks = 0;
  int n_fail   = 0;

  crit_fill_unit #(.WORDS(WORDS), .DATA_W(DATA_W), .LINE_W(LINE_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_word(miss_word),
    .miss_wrap(miss_wrap), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
    .mem_req_word(mem_req_word), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .fill_we(fill_we), .fill_word(fill_word), .fill_data(fill_data),
    .line_done(line_done), .cpu_resume(cpu_resume),
    .cpu_resume_data(cpu_resume_data),
    .rd_valid(rd_valid), .rd_word(rd_word), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] mdat(int line, int w);
    return (32'(line) * 32'h100) ^ 32'(w) ^ 32'h3C00_0000;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic idle_inputs();
    miss_valid = 1'b0; miss_line = '0; miss_word = '0; miss_wrap = 1'b0;
    mem_rvalid = 1'b0; mem_rdata = '0; rd_valid = 1'b0; rd_word = '0;
  endtask

  // One full miss with a bench-side memory model; gap idle cycles between beats.
  task automatic do_miss(int line, int crit, bit wrap, int gap);
    int start;
    int resumes;
    int w0;
    start   = wrap ? crit : 0;
    resumes = 0;
    w0      = start;
    @(negedge clk);
    miss_valid = 1'b1; miss_line = LINE_W'(line);
    miss_word = IDX_W'(crit); miss_wrap = wrap;
    #1;
    check("R2 req_valid", 64'(mem_req_valid), 64'd1);
    check("R2 req_word",  64'(mem_req_word), 64'(start));
    check("R2 req_line",  64'(mem_req_line), 64'(line));
    @(negedge clk);
    miss_valid = 1'b0; rd_valid = 1'b1; rd_word = IDX_W'(crit);
    #1;
    check("R2 busy", 64'(busy), 64'd1);
    check("R10 cleared", 64'(rd_ready), 64'd0);
    for (int k = 0; k < WORDS; k++) begin
      int w;
      w = (start + k) % WORDS;
      if (k > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          mem_rvalid = 1'b0;
          miss_valid = 1'b1; miss_line = LINE_W'(line + 99);
          miss_word = IDX_W'((crit + 3) % WORDS); miss_wrap = ~wrap;
          rd_valid = 1'b1;
          rd_word = (g == 0) ? IDX_W'(w0) : IDX_W'(w);
          #1;
          check("R7 ignored miss", 64'(mem_req_valid), 64'd0);
          check("R7 no write in gap", 64'(fill_we), 64'd0);
          if (g == 0) begin
            check("R9 ready written", 64'(rd_ready), 64'd1);
            check("R9 data written", 64'(rd_data), 64'(mdat(line, w0)));
          end else begin
            check("R9 not yet written", 64'(rd_ready), 64'd0);
          end
        end
      end
      @(negedge clk);
      miss_valid = 1'b0; miss_wrap = wrap;
      mem_rvalid = 1'b1; mem_rdata = mdat(line, w);
      rd_valid = 1'b1; rd_word = IDX_W'(w);
      #1;
      check(wrap ? "R3 fill_we" : "R4 fill_we", 64'(fill_we), 64'd1);
      check(wrap ? "R3 order" : "R4 order", 64'(fill_word), 64'(w));
      check("R3 data", 64'(fill_data), 64'(mdat(line, w)));
      check("R5 release cycle", 64'(cpu_resume), 64'(w == crit));
      if (cpu_resume) begin
        resumes++;
        check("R5 release data", 64'(cpu_resume_data), 64'(mdat(line, crit)));
      end
      check("R6 done beat", 64'(line_done), 64'(k == WORDS - 1));
      check("R9 same-cycle read", 64'(rd_ready), 64'd0);
    end
    @(negedge clk);
    mem_rvalid = 1'b0; rd_valid = 1'b0;
    #1;
    check("R5 one release", 64'(resumes), 64'd1);
    check("R6 idle after", 64'(busy), 64'd0);
  endtask

  task automatic test_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 req", 64'(mem_req_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 fill_we", 64'(fill_we), 64'd0);
    check("R1 done", 64'(line_done), 64'd0);
    check("R1 resume", 64'(cpu_resume), 64'd0);
    check("R1 rd_ready", 64'(rd_ready), 64'd0);
  endtask

  task automatic test_idle_beats();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      mem_rvalid = 1'b1; mem_rdata = 32'hDEAD_0000 + 32'(i);
      #1;
      check("R8 no write idle", 64'(fill_we), 64'd0);
      check("R8 no release idle", 64'(cpu_resume), 64'd0);
      check("R8 no done idle", 64'(line_done), 64'd0);
    end
    @(negedge clk);
    mem_rvalid = 1'b0;
  endtask

  task automatic test_reread(int line);
    for (int w = 0; w < WORDS; w++) begin
      @(negedge clk);
      rd_valid = 1'b1; rd_word = IDX_W'(w);
      #1;
      check("R9 reread ready", 64'(rd_ready), 64'd1);
      check("R9 reread data", 64'(rd_data), 64'(mdat(line, w)));
    end
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    test_reset();
    do_miss(17, 5, 1'b1, 0);            // R3 wrapped, mid-line
    do_miss(18, 5, 1'b0, 0);            // R4 linear, mid-line
    do_miss(19, 0, 1'b1, 2);            // R3 boundary word 0, with gaps
    do_miss(20, WORDS - 1, 1'b1, 2);    // R3 boundary top word, wraps at once
    do_miss(21, WORDS - 1, 1'b0, 2);    // R5 release on the last beat
    do_miss(22, 0, 1'b0, 1);            // R4 release on the first beat
    test_reread(22);
    test_idle_beats();
    do_miss(23, 3, 1'b1, 0);            // R10 covered by the clear check
    summary();
    $finish;
  end
endmodule